// File: doc/BRIEF.md
# Secure Context Save Sequencer

This block drives the save of a crypto engine's internal state before a power-down. After one start pulse it walks the engine's stores in a fixed order. For each 16-byte block it issues one request to a downstream encrypt-and-store datapath. A request names the store to read, a key index, a word-quad index within that key, and the destination address. The sequencer sends one request at a time and waits for that request's response before it issues the next one.

The block counts the blocks it has written and advances the destination address by one block after each success. It stops at the first request that reports failure. Before a save begins, the datapath's progress counter must read zero. After the last block, that counter must equal the count captured at start plus the size of the context. An extended variant, chosen per save, adds a public-key section just before the closing pattern block. The base context is 132 blocks and the extended context is 645 blocks.

Top module: `ctx_save_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `req_valid_o` are low, `err_code_o` is 0 and `total_o` is 0.
- R2: A save emits its sections in this order: random block (source 0), sticky blocks (source 1), AES table (source 2), RSA table (source 3), then, in extended mode only, public-key sticky (source 4) and public-key table (source 5), and finally the pattern block (source 6). The random, public-key sticky and pattern blocks use key 0 and quad 0. The sticky section is quad 0 and then quad 1, both with key 0. A base save is 132 requests.
- R3: The AES table runs over slots 0 to 15, with key index equal to the slot. Each slot emits quad 0 and quad 1 (the key halves), then quad 2 (original IV), then quad 3 (updated IV).
- R4: The RSA table covers two slots. Each slot emits its modulus and then its exponent, with key indices 1 then 0 for slot 0 and 3 then 2 for slot 1. Each key part runs quads 0 to 15.
- R5: In extended mode the public-key table runs over 4 slots of 128 quads each. The key index is the slot and the quad index is slot*128+quad. An extended save is 645 requests.
- R6: Request k carries address base+16*k, where base is `base_addr_i` captured at start. `total_o` equals the number of requests that completed without error.
- R7: A start while `prog_cnt_i` is nonzero sets `err_o` with `err_code_o`=1 and issues no request. `busy_o` stays low.
- R8: A response with `rsp_err_i` high ends the save at once, sets `err_o` with `err_code_o`=2 and issues no further request.
- R9: A start while busy has no effect on the running save, including its base address and mode.
- R10: After the last block, if `prog_cnt_i` equals the captured start count plus the context size, `done_o` rises. Otherwise `err_o` rises with `err_code_o`=3.
- R11: `done_o` and `err_o` are levels that hold until the next accepted start clears them, and they are never both high. A request held without `req_ready_i` keeps its valid, address, key and quad unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a save (level, sampled while idle) |
| ext_i | input | 1 | Select extended mode with the public-key section |
| base_addr_i | input | ADDR_W | Destination address of the first block |
| prog_cnt_i | input | CNT_W | Datapath progress counter in blocks |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted |
| req_src_o | output | 3 | Source store code |
| req_key_o | output | KEY_W | Key index |
| req_quad_o | output | QUAD_W | Word-quad index |
| req_addr_o | output | ADDR_W | Destination address |
| rsp_done_i | input | 1 | Response for the accepted request |
| rsp_err_i | input | 1 | Response reports failure |
| busy_o | output | 1 | Save in progress |
| done_o | output | 1 | Last save finished with a good count |
| err_o | output | 1 | Last save or start failed |
| err_code_o | output | 2 | 0 none, 1 already started, 2 request failed, 3 count mismatch |
| total_o | output | CNT_W | Blocks completed in the current or last save |

## Verification
The bench builds the block with its default sizes: 16 AES slots, two RSA slots of 16 quads each, four public-key slots of 128 quads each, and the public-key variant enabled. With these sizes every request of both the 132-block and the 645-block order is compared against an arithmetic model. Failure is injected at every position of the base order and at the section boundaries of the extended order. A skipped progress increment exercises the count check, and ready stalls, a start while busy and a nonzero starting counter are also driven.

// File: rtl/ctx_save_pkg.sv
package ctx_save_pkg;

   // Section code; the value is also the source select sent downstream.
   typedef enum logic [2:0] {
      SEC_RAND     = 3'd0,
      SEC_STICKY   = 3'd1,
      SEC_AESTAB   = 3'd2,
      SEC_RSATAB   = 3'd3,
      SEC_PKSTICKY = 3'd4,
      SEC_PKTAB    = 3'd5,
      SEC_PATTERN  = 3'd6
   } sect_e;

   typedef enum logic [1:0] {
      ERR_NONE    = 2'd0,
      ERR_ALREADY = 2'd1,
      ERR_REQ     = 2'd2,
      ERR_COUNT   = 2'd3
   } err_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_CHECK
   } st_e;

   // Blocks per AES slot: key low, key high, original IV, updated IV.
   localparam int AES_PARTS = 4;

endpackage

// File: rtl/ctx_save_cursor.sv
module ctx_save_cursor
   import ctx_save_pkg::*;
#(
   parameter int AES_SLOTS = 16,
   parameter int RSA_SLOTS = 2,
   parameter int RSA_QUADS = 16,
   parameter int PK_SLOTS  = 4,
   parameter int PK_QUADS  = 128,
   parameter int KEY_W     = 4,
   parameter int QUAD_W    = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic              ext_i,
   output logic [2:0]        sect_o,
   output logic [KEY_W-1:0]  key_o,
   output logic [QUAD_W-1:0] quad_o,
   output logic              last_o
);

   localparam int LEN_AES = AES_SLOTS * AES_PARTS;
   localparam int LEN_RSA = RSA_SLOTS * 2 * RSA_QUADS;
   localparam int LEN_PKT = PK_SLOTS * PK_QUADS;
   localparam int MAXLEN  = (LEN_PKT > LEN_AES) ?
                            ((LEN_PKT > LEN_RSA) ? LEN_PKT : LEN_RSA) :
                            ((LEN_AES > LEN_RSA) ? LEN_AES : LEN_RSA);
   localparam int N_W     = $clog2(MAXLEN + 1);

   sect_e          sect_q, nxt_sect;
   logic [N_W-1:0] n_q;
   int             sect_len;
   logic           sect_end;

   always_comb begin
      case (sect_q)
         SEC_STICKY: sect_len = 2;
         SEC_AESTAB: sect_len = LEN_AES;
         SEC_RSATAB: sect_len = LEN_RSA;
         SEC_PKTAB:  sect_len = LEN_PKT;
         default:    sect_len = 1;
      endcase
   end

   assign sect_end = (int'(n_q) == sect_len - 1);

   always_comb begin
      case (sect_q)
         SEC_RAND:     nxt_sect = SEC_STICKY;
         SEC_STICKY:   nxt_sect = SEC_AESTAB;
         SEC_AESTAB:   nxt_sect = SEC_RSATAB;
         SEC_RSATAB:   nxt_sect = ext_i ? SEC_PKSTICKY : SEC_PATTERN;
         SEC_PKSTICKY: nxt_sect = SEC_PKTAB;
         default:      nxt_sect = SEC_PATTERN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sect_q <= SEC_RAND;
         n_q    <= '0;
      end else if (load_i) begin
         sect_q <= SEC_RAND;
         n_q    <= '0;
      end else if (step_i) begin
         if (sect_end) begin
            sect_q <= nxt_sect;
            n_q    <= '0;
         end else begin
            n_q <= n_q + N_W'(1);
         end
      end
   end

   // Field decode from the linear index within the section
   always_comb begin
      int ni;
      int slot;
      int part;
      ni     = int'(n_q);
      slot   = 0;
      part   = 0;
      key_o  = '0;
      quad_o = '0;
      case (sect_q)
         SEC_STICKY: quad_o = QUAD_W'(ni);
         SEC_AESTAB: begin
            key_o  = KEY_W'(ni / AES_PARTS);
            quad_o = QUAD_W'(ni % AES_PARTS);
         end
         SEC_RSATAB: begin
            slot   = ni / (2 * RSA_QUADS);
            part   = (ni / RSA_QUADS) % 2;
            key_o  = KEY_W'(slot * 2 + 1 - part);
            quad_o = QUAD_W'(ni % RSA_QUADS);
         end
         SEC_PKTAB: begin
            key_o  = KEY_W'(ni / PK_QUADS);
            quad_o = QUAD_W'(ni);
         end
         default: ;
      endcase
   end

   assign sect_o = sect_q;
   assign last_o = (sect_q == SEC_PATTERN);

   // R5
   base_skips_pk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_i |-> (sect_q != SEC_PKSTICKY && sect_q != SEC_PKTAB));

   // R2
   pattern_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sect_q == SEC_PATTERN && !load_i) |=> sect_q == SEC_PATTERN);

endmodule

// File: rtl/ctx_save_addr.sv
module ctx_save_addr #(
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 12,
   parameter int BLK_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CNT_W-1:0]  cnt_o
);

   localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(BLK_BYTES);

   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         addr_q <= '0;
         cnt_q  <= '0;
      end else if (load_i) begin
         base_q <= base_i;
         addr_q <= base_i;
         cnt_q  <= '0;
      end else if (step_i) begin
         addr_q <= addr_q + STRIDE;
         cnt_q  <= cnt_q + CNT_W'(1);
      end
   end

   assign addr_o = addr_q;
   assign cnt_o  = cnt_q;

   // R6
   addr_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_o == base_q + ADDR_W'(cnt_o) * STRIDE);

endmodule

// File: rtl/ctx_save_seq.sv
module ctx_save_seq
   import ctx_save_pkg::*;
#(
   parameter int AES_SLOTS = 16,
   parameter int RSA_SLOTS = 2,
   parameter int RSA_QUADS = 16,
   parameter int PK_SLOTS  = 4,
   parameter int PK_QUADS  = 128,
   parameter bit HAS_PK    = 1'b1,
   parameter int ADDR_W    = 32,
   parameter int CNT_W     = 12,
   parameter int KEY_W     = 4,
   parameter int QUAD_W    = 9,
   parameter int BLK_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              ext_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic [CNT_W-1:0]  prog_cnt_i,
   output logic              req_valid_o,
   input  logic              req_ready_i,
   output logic [2:0]        req_src_o,
   output logic [KEY_W-1:0]  req_key_o,
   output logic [QUAD_W-1:0] req_quad_o,
   output logic [ADDR_W-1:0] req_addr_o,
   input  logic              rsp_done_i,
   input  logic              rsp_err_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [1:0]        err_code_o,
   output logic [CNT_W-1:0]  total_o
);

   localparam int TOT_BASE = 1 + 2 + AES_SLOTS * AES_PARTS + RSA_SLOTS * 2 * RSA_QUADS + 1;
   localparam int TOT_EXT  = TOT_BASE + 1 + PK_SLOTS * PK_QUADS;

   // Elaboration-time parameter checks
   if ((1 << CNT_W) <= TOT_EXT) begin : g_bad_cnt_w
      $error("CNT_W too narrow for the context size");
   end
   if ((1 << KEY_W) < AES_SLOTS || (1 << KEY_W) < 2 * RSA_SLOTS) begin : g_bad_key_w
      $error("KEY_W too narrow for the slot counts");
   end
   if ((1 << QUAD_W) < PK_SLOTS * PK_QUADS) begin : g_bad_quad_w
      $error("QUAD_W too narrow for the public-key table");
   end

   st_e              state_q;
   err_e             code_q;
   logic             done_q, err_q, ext_q;
   logic             ext_sel;
   logic [CNT_W-1:0] start_cnt_q;
   logic [CNT_W-1:0] limit;
   logic             load, step, last;

   if (HAS_PK) begin : g_pk
      assign ext_sel = ext_i;
   end else begin : g_nopk
      assign ext_sel = 1'b0;
   end

   assign load  = (state_q == ST_IDLE) && start_i && (prog_cnt_i == '0);
   assign step  = (state_q == ST_WAIT) && rsp_done_i && !rsp_err_i;
   assign limit = start_cnt_q + (ext_q ? CNT_W'(TOT_EXT) : CNT_W'(TOT_BASE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         code_q      <= ERR_NONE;
         done_q      <= 1'b0;
         err_q       <= 1'b0;
         ext_q       <= 1'b0;
         start_cnt_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) begin
               done_q <= 1'b0;
               err_q  <= 1'b0;
               code_q <= ERR_NONE;
               if (prog_cnt_i != '0) begin
                  err_q  <= 1'b1;
                  code_q <= ERR_ALREADY;
               end else begin
                  ext_q       <= ext_sel;
                  start_cnt_q <= prog_cnt_i;
                  state_q     <= ST_ISSUE;
               end
            end
            ST_ISSUE: if (req_ready_i) state_q <= ST_WAIT;
            ST_WAIT: if (rsp_done_i) begin
               if (rsp_err_i) begin
                  err_q   <= 1'b1;
                  code_q  <= ERR_REQ;
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= last ? ST_CHECK : ST_ISSUE;
               end
            end
            default: begin
               if (prog_cnt_i == limit) begin
                  done_q <= 1'b1;
               end else begin
                  err_q  <= 1'b1;
                  code_q <= ERR_COUNT;
               end
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   ctx_save_cursor #(
      .AES_SLOTS (AES_SLOTS),
      .RSA_SLOTS (RSA_SLOTS),
      .RSA_QUADS (RSA_QUADS),
      .PK_SLOTS  (PK_SLOTS),
      .PK_QUADS  (PK_QUADS),
      .KEY_W     (KEY_W),
      .QUAD_W    (QUAD_W)
   ) u_cursor (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .step_i (step),
      .ext_i  (ext_q),
      .sect_o (req_src_o),
      .key_o  (req_key_o),
      .quad_o (req_quad_o),
      .last_o (last)
   );

   ctx_save_addr #(
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .BLK_BYTES (BLK_BYTES)
   ) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .step_i (step),
      .base_i (base_addr_i),
      .addr_o (req_addr_o),
      .cnt_o  (total_o)
   );

   assign req_valid_o = (state_q == ST_ISSUE);
   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = done_q;
   assign err_o       = err_q;
   assign err_code_o  = code_q;

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !req_ready_i) |=> req_valid_o && $stable(req_addr_o)
         && $stable(req_key_o) && $stable(req_quad_o) && $stable(req_src_o));

   // R11
   done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));

   // R7
   already_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && prog_cnt_i != '0) |=> !busy_o && err_o
         && err_code_o == ERR_ALREADY);

   // R8
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && rsp_done_i && rsp_err_i) |=> !busy_o && !req_valid_o
         && err_code_o == ERR_REQ);

   // R9
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !rsp_done_i && state_q != ST_CHECK) |=> busy_o);

   // R10
   success_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> total_o == (ext_q ? CNT_W'(TOT_EXT) : CNT_W'(TOT_BASE)));

endmodule

// File: tb/ctx_save_seq_bench.sv
module ctx_save_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i, ext_i;
   logic [31:0] base_addr_i;
   logic [11:0] prog;
   logic        req_valid_o, req_ready_i;
   logic [2:0]  req_src_o;
   logic [3:0]  req_key_o;
   logic [8:0]  req_quad_o;
   logic [31:0] req_addr_o;
   logic        rsp_done_i, rsp_err_i;
   logic        busy_o, done_o, err_o;
   logic [1:0]  err_code_o;
   logic [11:0] total_o;

   int          n_chk = 0;
   int          n_bad = 0;
   int          rsp_idx, req_seen, fail_at, skip_at, stall_cnt;
   bit          cur_ext, stall_en, hs_pending;
   logic [31:0] cur_base;

   always #4 clk = ~clk;

   ctx_save_seq u_ctx_save_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .ext_i       (ext_i),
      .base_addr_i (base_addr_i),
      .prog_cnt_i  (prog),
      .req_valid_o (req_valid_o),
      .req_ready_i (req_ready_i),
      .req_src_o   (req_src_o),
      .req_key_o   (req_key_o),
      .req_quad_o  (req_quad_o),
      .req_addr_o  (req_addr_o),
      .rsp_done_i  (rsp_done_i),
      .rsp_err_i   (rsp_err_i),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .err_o       (err_o),
      .err_code_o  (err_code_o),
      .total_o     (total_o)
   );

   task automatic check(input string tag, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // Expected {src, key, quad} of request k
   function automatic logic [15:0] exp_word(input int k, input bit ext);
      int j;
      if (k == 0) return {3'd0, 4'd0, 9'd0};
      if (k < 3) return {3'd1, 4'd0, 9'(k - 1)};
      if (k < 67) begin
         j = k - 3;
         return {3'd2, 4'(j / 4), 9'(j % 4)};
      end
      if (k < 131) begin
         j = k - 67;
         return {3'd3, 4'((j / 32) * 2 + 1 - (j / 16) % 2), 9'(j % 16)};
      end
      if (ext && k == 131) return {3'd4, 4'd0, 9'd0};
      if (ext && k < 644) begin
         j = k - 132;
         return {3'd5, 4'(j / 128), 9'(j)};
      end
      return {3'd6, 4'd0, 9'd0};
   endfunction

   function automatic string sect_tag(input int k, input bit ext);
      if (k < 3 || (!ext && k >= 131) || (ext && k >= 644)) return "R2";
      if (k < 67) return "R3";
      if (k < 131) return "R4";
      return "R5";
   endfunction

   // Downstream datapath model
   always @(negedge clk) begin
      if (!rst_n) begin
         rsp_done_i  = 1'b0;
         rsp_err_i   = 1'b0;
         req_ready_i = 1'b0;
         hs_pending  = 1'b0;
         stall_cnt   = 0;
      end else begin
         rsp_done_i = 1'b0;
         rsp_err_i  = 1'b0;
         if (hs_pending) begin
            rsp_done_i = 1'b1;
            if (rsp_idx == fail_at) rsp_err_i = 1'b1;
            else if (rsp_idx != skip_at) prog = prog + 12'd1;
            rsp_idx++;
            hs_pending = 1'b0;
         end
         stall_cnt++;
         req_ready_i = !(stall_en && (stall_cnt % 3 == 0));
         if (req_valid_o && req_ready_i) begin
            req_seen++;
            check(sect_tag(rsp_idx, cur_ext), $sformatf("fields of request %0d", rsp_idx),
                  {req_src_o, req_key_o, req_quad_o}, exp_word(rsp_idx, cur_ext));
            check("R6", $sformatf("address of request %0d", rsp_idx),
                  req_addr_o, cur_base + 32'(16 * rsp_idx));
            hs_pending = 1'b1;
         end
      end
   end

   task automatic run_save(input bit ext, input logic [31:0] base, input int fail,
                           input int skip, input bit stall, input int poke);
      int cyc;
      cur_ext  = ext;
      cur_base = base;
      fail_at  = fail;
      skip_at  = skip;
      stall_en = stall;
      rsp_idx  = 0;
      req_seen = 0;
      prog     = 12'd0;
      ext_i       = ext;
      base_addr_i = base;
      start_i     = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      cyc = 0;
      while (busy_o) begin
         if (poke > 0 && cyc == poke) begin
            start_i     = 1'b1;
            base_addr_i = 32'h5A5A_0000;
            ext_i       = !ext;
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      start_i = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start_i = 1'b0; ext_i = 1'b0; base_addr_i = '0; prog = '0;
      fail_at = -1; skip_at = -1; rsp_idx = 0; req_seen = 0;
      cur_ext = 1'b0; stall_en = 1'b0; cur_base = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "busy", busy_o, 0);
      check("R1", "done", done_o, 0);
      check("R1", "err", err_o, 0);
      check("R1", "valid", req_valid_o, 0);
      check("R1", "code", err_code_o, 0);
      check("R1", "total", total_o, 0);

      // R2 R3 R4 R6 R10 base save with stalls
      run_save(1'b0, 32'h0004_0000, -1, -1, 1'b1, 0);
      check("R10", "done", done_o, 1);
      check("R10", "err", err_o, 0);
      check("R2", "total base", total_o, 132);
      check("R2", "requests base", req_seen, 132);

      // R11 done holds while idle, cleared by next start
      repeat (8) @(negedge clk);
      check("R11", "done held", done_o, 1);
      ext_i = 1'b1; base_addr_i = 32'h0010_0000; cur_ext = 1'b1; cur_base = 32'h0010_0000;
      rsp_idx = 0; req_seen = 0; prog = '0; fail_at = -1; skip_at = -1; stall_en = 1'b0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check("R11", "done cleared", done_o, 0);
      check("R11", "busy after start", busy_o, 1);
      // R5 extended save completes
      while (busy_o) @(negedge clk);
      check("R10", "done ext", done_o, 1);
      check("R5", "total ext", total_o, 645);
      check("R5", "requests ext", req_seen, 645);

      // R9 start while busy ignored
      run_save(1'b0, 32'h0020_0000, -1, -1, 1'b1, 40);
      check("R9", "done", done_o, 1);
      check("R9", "total", total_o, 132);
      check("R9", "requests", req_seen, 132);

      // R7 already triggered
      prog = 12'd5; req_seen = 0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check("R7", "err", err_o, 1);
      check("R7", "code", err_code_o, 1);
      check("R7", "busy", busy_o, 0);
      repeat (5) @(negedge clk);
      check("R7", "no request", req_seen, 0);
      check("R11", "err held", err_o, 1);
      prog = 12'd0;

      // R8 failure at every base position
      for (int k = 0; k < 132; k++) begin
         run_save(1'b0, 32'h0100_0000, k, -1, k[0], 0);
         check("R8", $sformatf("code fail %0d", k), err_code_o, 2);
         check("R8", $sformatf("total fail %0d", k), total_o, k);
         check("R8", $sformatf("requests fail %0d", k), req_seen, k + 1);
         check("R8", $sformatf("done fail %0d", k), done_o, 0);
      end
      // R8 failure across extended section boundaries
      for (int i = 0; i < 4; i++) begin
         int pos;
         pos = (i == 0) ? 131 : (i == 1) ? 132 : (i == 2) ? 500 : 644;
         run_save(1'b1, 32'h0200_0000, pos, -1, 1'b0, 0);
         repeat (3) @(negedge clk);
         check("R8", $sformatf("ext code fail %0d", pos), err_code_o, 2);
         check("R8", $sformatf("ext requests fail %0d", pos), req_seen, pos + 1);
      end

      // R10 count mismatch
      run_save(1'b0, 32'h0300_0000, -1, 50, 1'b0, 0);
      check("R10", "mismatch err", err_o, 1);
      check("R10", "mismatch code", err_code_o, 3);
      check("R10", "mismatch done", done_o, 0);
      check("R6", "mismatch total", total_o, 132);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule